// File: doc/BRIEF.md
# Scoped Lock Consistency Sequencer

This block stands beside the processor nodes of a shared-memory machine whose caches are not kept coherent by hardware. Each node hands it lock requests (acquire) and unlock requests (release), each tagged with a consistency scope. For an acquire the block first obtains the lock and then, only if needed, orders a whole-cache invalidate. For a release it first drains the write buffer and then gives the lock back. The cache, the write buffer and the lock arbiter are external responders reached through level command / single-cycle completion handshakes.

To skip invalidations that cannot matter, every write-buffer drain and every performed invalidate is stamped from one shared activity counter. A per-scope table keeps the stamp of the latest drain in that scope, and every node keeps the stamp of its own latest invalidate. The counter is shared by all node sequencers through a round-robin port that hands out at most one stamp per cycle, so stamps are unique and strictly ordered. A shared counter tallies how many invalidations were skipped.

Top module: `scoped_sync_unit`

## Requirements
- R1: For an acquire, the node's lock_req is raised first and held until lock_grant; inv_cmd is raised only after the lock grant has been received.
- R2: For a release, flush_cmd is raised first and held until flush_done; unlock_req is raised only after flush_done and a stamp grant.
- R3: The activity counter starts at 1 after reset, grants at most one stamp per cycle, and advances by exactly one per grant, so no two stamps are equal.
- R4: An acquire whose scope's last-drain stamp is strictly less than the node's last-invalidate stamp issues no inv_cmd and ends with done and done_skipped both high; flushes in other scopes have no effect on this decision.
- R5: Otherwise the acquire takes a new stamp into the node's last-invalidate register, raises inv_cmd until inv_done, and ends with done high and done_skipped low.
- R6: After reset req_ready is high for every node, all command outputs, done and skip_count are 0, all table entries and last-invalidate registers are 0, so the first acquire of each node invalidates.
- R7: req_ready is high only while the node is idle; once a request is accepted it stays low until the single-cycle done pulse, and is high again in the cycle after done.
- R8: skip_count increases in the cycle of done by the number of nodes whose done_skipped is high in that cycle (two or more may skip in the same cycle).
- R9: A node waiting for a stamp is granted within NODES cycles, the grant rotating round-robin from the node after the last one served.
- R10: A release always ends with done high and done_skipped low; its drain stamp is written to the table entry of its own scope.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NODES | Per node: request present |
| req_release | input | NODES | Per node: 1 = release, 0 = acquire |
| req_scope | input | NODES*SCOPE_W | Per node: scope number of the request |
| req_ready | output | NODES | Per node: idle, request accepted this cycle if valid |
| done | output | NODES | Per node: one-cycle completion pulse |
| done_skipped | output | NODES | Per node: with done, the invalidate was omitted |
| lock_req | output | NODES | Per node: lock request, held until grant |
| lock_grant | input | NODES | Per node: one-cycle lock grant |
| unlock_req | output | NODES | Per node: unlock request, held until ack |
| unlock_ack | input | NODES | Per node: one-cycle unlock acknowledge |
| inv_cmd | output | NODES | Per node: whole-cache invalidate, held until done |
| inv_done | input | NODES | Per node: one-cycle invalidate completion |
| flush_cmd | output | NODES | Per node: whole write-buffer drain, held until done |
| flush_done | input | NODES | Per node: one-cycle drain completion |
| skip_count | output | PERF_W | Number of invalidations omitted since reset |

## Verification
Two node sequencers can want a stamp in the same cycle, and two nodes can finish a skipped acquire in the same cycle. The bench provokes both by issuing paired requests on both nodes in one cycle with immediately answering responders, and then by a long random mix. Stamp order is judged from the cycles in which inv_cmd and unlock_req rise, which the bench folds into its own counter and table model; the same-cycle skips are judged by skip_count rising by two at once.

// File: rtl/scu_pkg.sv
// Shared types of the scoped lock consistency sequencer.
// Assumes nothing beyond a synthesizable enum encoding.
package scu_pkg;

    // Phases a node sequencer walks through for one request.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOCK,
        ST_CHECK,
        ST_INV_STAMP,
        ST_INV,
        ST_FLUSH,
        ST_FL_STAMP,
        ST_UNLOCK,
        ST_DONE
    } node_state_e;

endpackage

// File: rtl/stamp_arbiter.sv
// Shared activity counter with a round-robin request/grant port.
// Hands at most one stamp per cycle; the granted requester reads the
// current counter value in the grant cycle and the counter advances at
// the following edge. Assumes requests are held until granted.
module stamp_arbiter #(
    parameter int NODES   = 2,
    parameter int STAMP_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NODES-1:0]   req,
    output logic [NODES-1:0]   gnt,
    output logic [STAMP_W-1:0] stamp
);

    localparam int PTR_W = (NODES > 1) ? $clog2(NODES) : 1;

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_d;
    logic             found;
    int               idx;

    // Pick the first requester at or after the rotating pointer.
    always_comb begin
        gnt   = '0;
        ptr_d = ptr_q;
        found = 1'b0;
        idx   = 0;
        for (int i = 0; i < NODES; i++) begin
            idx = (int'(ptr_q) + i) % NODES;
            if (!found && req[idx]) begin
                found    = 1'b1;
                gnt[idx] = 1'b1;
                ptr_d    = PTR_W'((idx + 1) % NODES);
            end
        end
    end

    // Advance the pointer and the counter on every grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            stamp <= STAMP_W'(1);
        end else if (found) begin
            ptr_q <= ptr_d;
            stamp <= stamp + STAMP_W'(1);
        end
    end

endmodule

// File: rtl/flush_stamp_table.sv
// Per-scope table of the latest write-buffer drain stamp.
// One write port (writers are serialized by the stamp grant) and one
// combinational read port per node. All entries clear to 0 on reset.
module flush_stamp_table #(
    parameter int NODES   = 2,
    parameter int SCOPES  = 16,
    parameter int STAMP_W = 32,
    parameter int SCOPE_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [SCOPE_W-1:0]         waddr,
    input  logic [STAMP_W-1:0]         wdata,
    input  logic [NODES*SCOPE_W-1:0]   raddr,
    output logic [NODES*STAMP_W-1:0]   rdata
);

    logic [STAMP_W-1:0] entry [SCOPES];

    for (genvar s = 0; s < SCOPES; s++) begin : g_entry
        // Hold one scope's stamp; load it when that scope is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry[s] <= '0;
            end else if (we && (waddr == SCOPE_W'(s))) begin
                entry[s] <= wdata;
            end
        end
    end

    for (genvar n = 0; n < NODES; n++) begin : g_read
        assign rdata[n*STAMP_W +: STAMP_W] = entry[raddr[n*SCOPE_W +: SCOPE_W]];
    end

endmodule

// File: rtl/node_sequencer.sv
// One node's acquire/release sequencer.
// Acquire: lock, compare the scope's drain stamp with the local
// invalidate stamp, then either finish (skip) or stamp and invalidate.
// Release: drain the write buffer, stamp it into the table, unlock.
// Assumes all completion inputs are single-cycle pulses that answer a
// held command.
module node_sequencer
    import scu_pkg::*;
#(
    parameter int STAMP_W = 32,
    parameter int SCOPE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_release,
    input  logic [SCOPE_W-1:0] req_scope,
    output logic               req_ready,
    output logic               done,
    output logic               done_skipped,
    output logic               lock_req,
    input  logic               lock_grant,
    output logic               unlock_req,
    input  logic               unlock_ack,
    output logic               inv_cmd,
    input  logic               inv_done,
    output logic               flush_cmd,
    input  logic               flush_done,
    output logic               stamp_req,
    input  logic               stamp_gnt,
    input  logic [STAMP_W-1:0] stamp_val,
    output logic [SCOPE_W-1:0] tbl_raddr,
    input  logic [STAMP_W-1:0] tbl_rdata,
    output logic               tbl_we,
    output logic [SCOPE_W-1:0] tbl_waddr,
    output logic [STAMP_W-1:0] tbl_wdata,
    output logic               skip_evt
);

    node_state_e        state_q;
    node_state_e        state_d;
    logic [SCOPE_W-1:0] scope_q;
    logic               skip_q;
    logic [STAMP_W-1:0] last_inv_q;
    logic               skip_now;

    assign skip_now = (state_q == ST_CHECK) && (tbl_rdata < last_inv_q);

    // Next phase from the current phase and the responder pulses.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = req_release ? ST_FLUSH : ST_LOCK;
            ST_LOCK:      if (lock_grant) state_d = ST_CHECK;
            ST_CHECK:     state_d = skip_now ? ST_DONE : ST_INV_STAMP;
            ST_INV_STAMP: if (stamp_gnt) state_d = ST_INV;
            ST_INV:       if (inv_done) state_d = ST_DONE;
            ST_FLUSH:     if (flush_done) state_d = ST_FL_STAMP;
            ST_FL_STAMP:  if (stamp_gnt) state_d = ST_UNLOCK;
            ST_UNLOCK:    if (unlock_ack) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the scope and the skip decision of the current request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scope_q <= '0;
            skip_q  <= 1'b0;
        end else if (state_q == ST_IDLE && req_valid) begin
            scope_q <= req_scope;
            skip_q  <= 1'b0;
        end else if (state_q == ST_CHECK) begin
            skip_q  <= skip_now;
        end
    end

    // Node-local stamp of the latest performed invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    last_inv_q <= '0;
        else if (state_q == ST_INV_STAMP && stamp_gnt) last_inv_q <= stamp_val;
    end

    assign req_ready    = (state_q == ST_IDLE);
    assign lock_req     = (state_q == ST_LOCK);
    assign inv_cmd      = (state_q == ST_INV);
    assign flush_cmd    = (state_q == ST_FLUSH);
    assign unlock_req   = (state_q == ST_UNLOCK);
    assign done         = (state_q == ST_DONE);
    assign done_skipped = (state_q == ST_DONE) && skip_q;
    assign stamp_req    = (state_q == ST_INV_STAMP) || (state_q == ST_FL_STAMP);
    assign tbl_raddr    = scope_q;
    assign tbl_we       = (state_q == ST_FL_STAMP) && stamp_gnt;
    assign tbl_waddr    = scope_q;
    assign tbl_wdata    = stamp_val;
    assign skip_evt     = skip_now;

endmodule

// File: rtl/scoped_sync_unit.sv
// Top: NODES acquire/release sequencers sharing one activity counter,
// one per-scope drain-stamp table and one skipped-invalidate counter.
// Assumes the external lock arbiter, caches and write buffers answer
// each held command with a single-cycle completion pulse.
module scoped_sync_unit #(
    parameter int  NODES   = 2,
    parameter int  SCOPES  = 16,
    parameter int  STAMP_W = 32,
    parameter int  PERF_W  = 16,
    localparam int SCOPE_W = $clog2(SCOPES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NODES-1:0]         req_valid,
    input  logic [NODES-1:0]         req_release,
    input  logic [NODES*SCOPE_W-1:0] req_scope,
    output logic [NODES-1:0]         req_ready,
    output logic [NODES-1:0]         done,
    output logic [NODES-1:0]         done_skipped,
    output logic [NODES-1:0]         lock_req,
    input  logic [NODES-1:0]         lock_grant,
    output logic [NODES-1:0]         unlock_req,
    input  logic [NODES-1:0]         unlock_ack,
    output logic [NODES-1:0]         inv_cmd,
    input  logic [NODES-1:0]         inv_done,
    output logic [NODES-1:0]         flush_cmd,
    input  logic [NODES-1:0]         flush_done,
    output logic [PERF_W-1:0]        skip_count
);

    logic [NODES-1:0]         stamp_req_w;
    logic [NODES-1:0]         gnt_w;
    logic [STAMP_W-1:0]       stamp_w;
    logic [NODES*SCOPE_W-1:0] raddr_w;
    logic [NODES*STAMP_W-1:0] rdata_w;
    logic [NODES-1:0]         node_we;
    logic [NODES*SCOPE_W-1:0] node_waddr;
    logic [NODES*STAMP_W-1:0] node_wdata;
    logic [NODES-1:0]         skip_evt_w;
    logic                     tbl_we;
    logic [SCOPE_W-1:0]       tbl_waddr;
    logic [STAMP_W-1:0]       tbl_wdata;

    stamp_arbiter #(
        .NODES  (NODES),
        .STAMP_W(STAMP_W)
    ) u_stamp (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (stamp_req_w),
        .gnt  (gnt_w),
        .stamp(stamp_w)
    );

    for (genvar n = 0; n < NODES; n++) begin : g_node
        node_sequencer #(
            .STAMP_W(STAMP_W),
            .SCOPE_W(SCOPE_W)
        ) u_seq (
            .clk         (clk),
            .rst_n       (rst_n),
            .req_valid   (req_valid[n]),
            .req_release (req_release[n]),
            .req_scope   (req_scope[n*SCOPE_W +: SCOPE_W]),
            .req_ready   (req_ready[n]),
            .done        (done[n]),
            .done_skipped(done_skipped[n]),
            .lock_req    (lock_req[n]),
            .lock_grant  (lock_grant[n]),
            .unlock_req  (unlock_req[n]),
            .unlock_ack  (unlock_ack[n]),
            .inv_cmd     (inv_cmd[n]),
            .inv_done    (inv_done[n]),
            .flush_cmd   (flush_cmd[n]),
            .flush_done  (flush_done[n]),
            .stamp_req   (stamp_req_w[n]),
            .stamp_gnt   (gnt_w[n]),
            .stamp_val   (stamp_w),
            .tbl_raddr   (raddr_w[n*SCOPE_W +: SCOPE_W]),
            .tbl_rdata   (rdata_w[n*STAMP_W +: STAMP_W]),
            .tbl_we      (node_we[n]),
            .tbl_waddr   (node_waddr[n*SCOPE_W +: SCOPE_W]),
            .tbl_wdata   (node_wdata[n*STAMP_W +: STAMP_W]),
            .skip_evt    (skip_evt_w[n])
        );
    end

    // Merge the node write requests; the stamp grant makes them one-hot.
    always_comb begin
        tbl_we    = 1'b0;
        tbl_waddr = '0;
        tbl_wdata = '0;
        for (int n = 0; n < NODES; n++) begin
            if (node_we[n]) begin
                tbl_we    = 1'b1;
                tbl_waddr = node_waddr[n*SCOPE_W +: SCOPE_W];
                tbl_wdata = node_wdata[n*STAMP_W +: STAMP_W];
            end
        end
    end

    flush_stamp_table #(
        .NODES  (NODES),
        .SCOPES (SCOPES),
        .STAMP_W(STAMP_W),
        .SCOPE_W(SCOPE_W)
    ) u_table (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (tbl_we),
        .waddr(tbl_waddr),
        .wdata(tbl_wdata),
        .raddr(raddr_w),
        .rdata(rdata_w)
    );

    // Tally omitted invalidations, several nodes possibly at once.
    always_ff @(posedge clk) begin
        if (!rst_n) skip_count <= '0;
        else        skip_count <= skip_count + PERF_W'($countones(skip_evt_w));
    end

endmodule

// File: rtl/scu_checker.sv
// Protocol and ordering properties of scoped_sync_unit, attached by bind.
// Observes top ports plus the internal stamp request/grant wires.
module scu_checker #(
    parameter int NODES   = 2,
    parameter int STAMP_W = 32,
    parameter int PERF_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NODES-1:0]   req_valid,
    input logic [NODES-1:0]   req_ready,
    input logic [NODES-1:0]   done,
    input logic [NODES-1:0]   done_skipped,
    input logic [NODES-1:0]   lock_req,
    input logic [NODES-1:0]   lock_grant,
    input logic [NODES-1:0]   flush_cmd,
    input logic [NODES-1:0]   flush_done,
    input logic [NODES-1:0]   inv_cmd,
    input logic [NODES-1:0]   stamp_req,
    input logic [NODES-1:0]   gnt,
    input logic [STAMP_W-1:0] stamp,
    input logic [PERF_W-1:0]  skip_count
);

    p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_stamp_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> (stamp == $past(stamp) + STAMP_W'(1)));

    p_stamp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(|gnt) |=> $stable(stamp));

    p_skip_tally_r8: assert property (@(posedge clk) disable iff (!rst_n)
        skip_count == $past(skip_count) + PERF_W'($countones(done_skipped)));

    for (genvar n = 0; n < NODES; n++) begin : g_node
        logic [15:0] wait_q;

        // Count cycles a node has waited for its stamp.
        always_ff @(posedge clk) begin
            if (!rst_n)                       wait_q <= '0;
            else if (stamp_req[n] && !gnt[n]) wait_q <= wait_q + 16'd1;
            else                              wait_q <= '0;
        end

        p_fair_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
            int'(wait_q) < NODES);

        p_grant_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[n] |-> stamp_req[n]);

        p_lock_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(lock_req[n]) |-> $past(lock_grant[n]));

        p_inv_not_with_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(inv_cmd[n]) |-> !$past(lock_req[n]));

        p_flush_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flush_cmd[n]) |-> $past(flush_done[n]));

        p_skip_no_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
            done_skipped[n] |-> (done[n] && !inv_cmd[n] && !$past(inv_cmd[n])));

        p_busy_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
            done[n] |-> !req_ready[n]);

        p_ready_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
            done[n] |=> req_ready[n]);

        p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(req_ready[n]) |-> $past(req_valid[n]));
    end

endmodule

bind scoped_sync_unit scu_checker #(
    .NODES  (NODES),
    .STAMP_W(STAMP_W),
    .PERF_W (PERF_W)
) u_scu_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .done        (done),
    .done_skipped(done_skipped),
    .lock_req    (lock_req),
    .lock_grant  (lock_grant),
    .flush_cmd   (flush_cmd),
    .flush_done  (flush_done),
    .inv_cmd     (inv_cmd),
    .stamp_req   (stamp_req_w),
    .gnt         (gnt_w),
    .stamp       (stamp_w),
    .skip_count  (skip_count)
);

// File: tb/tb_scoped_sync_unit.sv
module tb_scoped_sync_unit;

    localparam int N  = 2;
    localparam int SC = 16;
    localparam int SW = 4;
    localparam int TW = 32;
    localparam int PW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [N-1:0]    req_release = '0;
    logic [N*SW-1:0] req_scope = '0;
    logic [N-1:0]    req_ready;
    logic [N-1:0]    done;
    logic [N-1:0]    done_skipped;
    logic [N-1:0]    lock_req;
    logic [N-1:0]    lock_grant = '0;
    logic [N-1:0]    unlock_req;
    logic [N-1:0]    unlock_ack = '0;
    logic [N-1:0]    inv_cmd;
    logic [N-1:0]    inv_done = '0;
    logic [N-1:0]    flush_cmd;
    logic [N-1:0]    flush_done = '0;
    logic [PW-1:0]   skip_count;

    always #5 clk = ~clk;

    scoped_sync_unit #(.NODES(N), .SCOPES(SC), .STAMP_W(TW), .PERF_W(PW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_release(req_release), .req_scope(req_scope),
        .req_ready(req_ready), .done(done), .done_skipped(done_skipped),
        .lock_req(lock_req), .lock_grant(lock_grant),
        .unlock_req(unlock_req), .unlock_ack(unlock_ack),
        .inv_cmd(inv_cmd), .inv_done(inv_done),
        .flush_cmd(flush_cmd), .flush_done(flush_done),
        .skip_count(skip_count)
    );

    int checks = 0;
    int fails  = 0;
    bit running = 0;
    bit rand_on = 0;
    bit fast    = 1;

    // Reference model: activity counter, drain table, per-node invalidate stamps.
    longint ctr_m = 1;
    longint tbl_m [SC];
    longint inv_m [N];
    longint skips_m = 0;

    bit     busy [N];
    bit     op_rel [N];
    int     op_scope [N];
    bit     lock_ok [N];
    bit     flush_ok [N];
    bit     inv_seen [N];
    bit     unl_seen [N];
    bit     exp_skip [N];
    bit     fl_on [N];
    int     fl_wait [N];
    bit     ready_chk [N];
    bit     last_skip [N];
    bit     dir_pend [N];
    bit     dir_rel [N];
    int     dir_scope [N];
    logic [N-1:0] p_inv = '0, p_unl = '0, p_lock = '0, p_flush = '0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit pred_skip(input longint tbl_stamp, input longint inv_stamp);
        return tbl_stamp < inv_stamp;
    endfunction

    // Observe outputs, fold stamp events into the model, judge completions.
    task automatic monitor();
        int ev = 0;
        bit any_done = 0;
        for (int n = 0; n < N; n++) begin
            if (ready_chk[n]) begin
                chk(req_ready[n] == 1'b1, "R7 ready after done", req_ready[n], 1);
                ready_chk[n] = 0;
            end
            if (inv_cmd[n] && !p_inv[n]) begin
                ev++;
                chk(lock_ok[n] && !op_rel[n], "R1 invalidate after lock", lock_ok[n], 1);
                chk(exp_skip[n] == 0, "R5 invalidate only when needed", exp_skip[n], 0);
                inv_m[n] = ctr_m;
                ctr_m++;
                inv_seen[n] = 1;
            end
            if (unlock_req[n] && !p_unl[n]) begin
                ev++;
                chk(flush_ok[n] && op_rel[n], "R2 unlock after drain", flush_ok[n], 1);
                chk(fl_wait[n] < N, "R9 stamp wait bound", fl_wait[n], N - 1);
                tbl_m[op_scope[n]] = ctr_m;
                ctr_m++;
                fl_on[n] = 0;
                unl_seen[n] = 1;
            end
        end
        if (ev > 0) chk(ev == 1, "R3 one stamp per cycle", ev, 1);
        for (int n = 0; n < N; n++) begin
            if (fl_on[n]) fl_wait[n]++;
            if (!lock_req[n] && p_lock[n]) begin
                lock_ok[n] = 1;
                exp_skip[n] = pred_skip(tbl_m[op_scope[n]], inv_m[n]);
            end
            if (!flush_cmd[n] && p_flush[n]) begin
                flush_ok[n] = 1;
                fl_on[n] = 1;
                fl_wait[n] = 0;
            end
            if (done[n]) begin
                any_done = 1;
                chk(busy[n], "R7 done only for accepted request", busy[n], 1);
                chk(req_ready[n] == 0, "R7 busy until done", req_ready[n], 0);
                if (op_rel[n]) begin
                    chk(done_skipped[n] == 0, "R10 release flag", done_skipped[n], 0);
                    chk(unl_seen[n], "R10 release unlocked", unl_seen[n], 1);
                end else if (exp_skip[n]) begin
                    chk(done_skipped[n] == 1 && !inv_seen[n], "R4 skipped acquire",
                        {inv_seen[n], done_skipped[n]}, 1);
                end else begin
                    chk(done_skipped[n] == 0 && inv_seen[n], "R5 invalidating acquire",
                        {inv_seen[n], done_skipped[n]}, 2);
                end
                if (done_skipped[n]) skips_m++;
                last_skip[n] = done_skipped[n];
                busy[n] = 0;
                ready_chk[n] = 1;
            end
        end
        if (any_done) chk(skip_count == PW'(skips_m), "R8 skip tally", skip_count, skips_m & 16'hFFFF);
        p_inv = inv_cmd; p_unl = unlock_req; p_lock = lock_req; p_flush = flush_cmd;
    endtask

    function automatic bit respond(input logic cmd, input logic prev_pulse);
        if (!cmd || prev_pulse) return 1'b0;
        if (fast) return 1'b1;
        return ($urandom % 3) == 0;
    endfunction

    // Drive responders and new requests for the next rising edge.
    task automatic drive();
        for (int n = 0; n < N; n++) begin
            lock_grant[n] = respond(lock_req[n], lock_grant[n]);
            inv_done[n]   = respond(inv_cmd[n], inv_done[n]);
            flush_done[n] = respond(flush_cmd[n], flush_done[n]);
            unlock_ack[n] = respond(unlock_req[n], unlock_ack[n]);
            req_valid[n]  = 1'b0;
            if (req_ready[n] && !busy[n] && (dir_pend[n] || (rand_on && ($urandom % 4) == 0))) begin
                if (dir_pend[n]) begin
                    op_rel[n] = dir_rel[n];
                    op_scope[n] = dir_scope[n];
                    dir_pend[n] = 0;
                end else begin
                    op_rel[n] = ($urandom % 3) == 0;
                    op_scope[n] = $urandom % 6;
                end
                req_valid[n] = 1'b1;
                req_release[n] = op_rel[n];
                req_scope[n*SW +: SW] = SW'(op_scope[n]);
                busy[n] = 1; lock_ok[n] = 0; flush_ok[n] = 0;
                inv_seen[n] = 0; unl_seen[n] = 0; exp_skip[n] = 0;
            end
        end
    endtask

    initial begin
        wait (running);
        forever begin
            @(negedge clk);
            monitor();
            drive();
        end
    end

    task automatic issue(input int n, input bit rel, input int scope);
        dir_rel[n] = rel;
        dir_scope[n] = scope;
        dir_pend[n] = 1;
    endtask

    task automatic wait_idle();
        @(posedge clk);
        while (dir_pend[0] || dir_pend[1] || busy[0] || busy[1]) @(posedge clk);
        @(posedge clk);
    endtask

    initial begin
        for (int s = 0; s < SC; s++) tbl_m[s] = 0;
        for (int n = 0; n < N; n++) begin
            inv_m[n] = 0; busy[n] = 0; dir_pend[n] = 0; fl_on[n] = 0; fl_wait[n] = 0;
            ready_chk[n] = 0; last_skip[n] = 0; lock_ok[n] = 0; flush_ok[n] = 0;
        end
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == '1, "R6 reset ready", req_ready, 3);
        chk((lock_req | unlock_req | inv_cmd | flush_cmd) == '0, "R6 reset commands",
            lock_req | unlock_req | inv_cmd | flush_cmd, 0);
        chk(done == '0 && skip_count == '0, "R6 reset done and tally", skip_count, 0);
        running = 1;
        @(posedge clk);

        issue(0, 0, 3); wait_idle();
        chk(last_skip[0] == 0, "R6 first acquire invalidates", last_skip[0], 0);
        issue(0, 0, 3); wait_idle();
        chk(last_skip[0] == 1, "R4 repeat acquire skipped", last_skip[0], 1);
        issue(1, 1, 3); wait_idle();
        chk(last_skip[1] == 0, "R10 release not skipped", last_skip[1], 0);
        issue(0, 0, 3); wait_idle();
        chk(last_skip[0] == 0, "R5 acquire after drain invalidates", last_skip[0], 0);
        issue(0, 0, 7); wait_idle();
        chk(last_skip[0] == 1, "R4 other scope drain ignored", last_skip[0], 1);
        issue(1, 0, 7); wait_idle();
        chk(last_skip[1] == 0, "R6 first acquire of node 1", last_skip[1], 0);
        issue(0, 1, 2); issue(1, 1, 9); wait_idle();
        issue(0, 0, 2); issue(1, 0, 9); wait_idle();
        chk(last_skip[0] == 0 && last_skip[1] == 0, "R3 contended stamps then invalidates",
            {last_skip[0], last_skip[1]}, 0);
        issue(0, 0, 5); issue(1, 0, 4); wait_idle();
        chk(last_skip[0] == 1 && last_skip[1] == 1, "R8 two skips in one cycle",
            {last_skip[0], last_skip[1]}, 3);
        chk(skip_count == PW'(skips_m), "R8 tally after paired skips", skip_count, skips_m);

        fast = 0;
        rand_on = 1;
        repeat (4000) @(posedge clk);
        rand_on = 0;
        wait_idle();
        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R7 watchdog actual=hung expected=idle");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule